// File: doc/BRIEF.md
# Interrupt Vector Status Modifier

This block resolves the interrupt requests of a two-channel serial controller and produces the interrupt line and the vector handed to the processor on acknowledge. Each channel has three sources: receive, transmit and external/status. That gives six request inputs, resolved by a fixed priority. The block keeps an in-service set so that handlers can nest. A source may interrupt only while no source of equal or higher priority is being serviced.

The vector returned is a base vector with a 3-bit code for the winning source written into it. Software chooses whether the code is inserted, and whether it lands in the low field (bits 3:1) or the high field (bits 6:4). A master enable gates all requests. An acknowledge strobe moves the current winner into service. A return strobe retires the highest-priority source in service. Both outputs are registered and reflect the inputs and state of the previous clock edge.

Top module: `irq_vector_mod`

## Requirements
- R1: Request bits are indexed 0 = channel A receive, 1 = channel A transmit, 2 = channel A external/status, 3 = channel B receive, 4 = channel B transmit, 5 = channel B external/status. The lowest pending index wins.
- R2: While the master enable is low, no request reaches the output, the interrupt line stays low, and an acknowledge has no effect on the in-service set.
- R3: The two low bits of the code give the source kind: transmit 00, external/status 01, receive 10, and receive with its channel's special-condition flag set 11. Flag bit 0 belongs to channel A.
- R4: The code's top bit is 1 for a channel A source and 0 for a channel B source.
- R5: When no enabled source is pending, the code is 011.
- R6: With the status-insert control low, the vector equals the base vector unchanged.
- R7: With status insert on, the code replaces vector bits 6:4 when the high-select control is 1 and bits 3:1 when it is 0. All other bits come from the base vector.
- R8: An acknowledge in a cycle where the interrupt is being raised puts the winning source in service. That source then no longer drives the interrupt line.
- R9: The interrupt line is raised when the winning source has no source of equal or higher priority in service. A higher-priority source does interrupt a lower one in service.
- R10: A return strobe removes the highest-priority source from the in-service set.
- R11: When acknowledge and return occur in the same cycle, the removal applies to the set as it stood before that edge, and the newly acknowledged source is then added.
- R12: After reset the interrupt line is 0, the vector is 0 and nothing is in service. The outputs follow the inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 6 | Pending request per source, index order as in R1 |
| spec_rx_i | input | 2 | Special receive condition flag per channel (bit 0 = A) |
| base_vec_i | input | 8 | Base interrupt vector |
| mie_i | input | 1 | Master interrupt enable |
| vis_i | input | 1 | Insert source code into vector |
| hi_sel_i | input | 1 | 1: code into bits 6:4, 0: code into bits 3:1 |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request, registered |
| vec_o | output | 8 | Modified vector, registered |

## Verification
The two functions that can collide are acknowledge and return. When both strobes land on the same edge, the in-service set both loses its top entry and gains the new winner. The bench provokes this with channel A transmit in service and channel A receive pending, then raises both strobes together. It judges the result at the ports through later patterns. With only receive requested, the line must stay low, which shows receive is in service and transmit was retired. A further return must then leave transmit free to interrupt.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    KIND_TX   = 2'b00,
    KIND_EXT  = 2'b01,
    KIND_RX   = 2'b10,
    KIND_SPEC = 2'b11
  } src_kind_e;

  localparam logic [CODE_W-1:0] CODE_NONE = 3'b011;
endpackage

// File: rtl/irqv_first.sv
// Fixed-priority pick: the lowest set index is returned one-hot.
module irqv_first #(
  parameter int N = 6
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] first_o
);
  always_comb begin
    first_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        first_o    = '0;
        first_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqv_service.sv
// In-service set: return retires the top entry, acknowledge adds one.
module irqv_service #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_oh_i,
  input  logic         clr_i,
  output logic [N-1:0] svc_o
);
  logic [N-1:0] top_oh;
  logic [N-1:0] clr_mask;

  irqv_first #(.N(N)) u_top (
    .vec_i   (svc_o),
    .first_o (top_oh)
  );

  assign clr_mask = clr_i ? top_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) svc_o <= '0;
    else     svc_o <= (svc_o & ~clr_mask) | set_oh_i;
  end

  // R8: at most one source enters service per acknowledge
  p_single_set_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_oh_i));

  // R8: an acknowledge alone grows the set by one
  p_ack_grows_r8: assert property (@(posedge clk) disable iff (rst)
    (|set_oh_i && !clr_i) |=> $countones(svc_o) == $countones($past(svc_o)) + 1);

  // R10: a return alone shrinks a non-empty set by one
  p_reti_shrinks_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && |svc_o && set_oh_i == '0) |=> $countones(svc_o) == $countones($past(svc_o)) - 1);

  // R10: the highest-priority entry is the one retired
  p_reti_top_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_oh_i == '0) |=> (svc_o & $past(top_oh)) == '0);
endmodule

// File: rtl/irqv_encode.sv
// Builds the source code and merges it into the base vector.
module irqv_encode
  import irqv_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int SRC_PER_CH = 3,
  parameter int VEC_W      = 8,
  parameter int LO_LSB     = 1,
  parameter int HI_LSB     = 4
) (
  input  logic [NUM_CH*SRC_PER_CH-1:0] win_oh_i,
  input  logic [NUM_CH-1:0]            spec_i,
  input  logic [VEC_W-1:0]             base_i,
  input  logic                         vis_i,
  input  logic                         hi_i,
  output logic [VEC_W-1:0]             vec_o
);
  localparam int N = NUM_CH * SRC_PER_CH;

  logic [CODE_W-1:0] code;
  src_kind_e         kind;
  logic              sp;
  int                ch;
  int                k;

  always_comb begin
    ch = 0;
    k  = 0;
    for (int i = 0; i < N; i++) begin
      if (win_oh_i[i]) begin
        ch = i / SRC_PER_CH;
        k  = i % SRC_PER_CH;
      end
    end
    sp = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c == ch) sp = spec_i[c];
    end
    case (k)
      0:       kind = sp ? KIND_SPEC : KIND_RX;
      1:       kind = KIND_TX;
      default: kind = KIND_EXT;
    endcase
    if (|win_oh_i) code = {(ch == 0), kind};
    else           code = CODE_NONE;
  end

  always_comb begin
    vec_o = base_i;
    if (vis_i) begin
      if (hi_i) vec_o[HI_LSB +: CODE_W] = code;
      else      vec_o[LO_LSB +: CODE_W] = code;
    end
  end
endmodule

// File: rtl/irq_vector_mod.sv
module irq_vector_mod #(
  parameter int NUM_CH     = 2,
  parameter int SRC_PER_CH = 3,
  parameter int VEC_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH*SRC_PER_CH-1:0] src_req_i,
  input  logic [NUM_CH-1:0]            spec_rx_i,
  input  logic [VEC_W-1:0]             base_vec_i,
  input  logic                         mie_i,
  input  logic                         vis_i,
  input  logic                         hi_sel_i,
  input  logic                         ack_i,
  input  logic                         reti_i,
  output logic                         irq_o,
  output logic [VEC_W-1:0]             vec_o
);
  localparam int N      = NUM_CH * SRC_PER_CH;
  localparam int LO_LSB = 1;
  localparam int HI_LSB = 4;

  logic [N-1:0]     req_en;
  logic [N-1:0]     win_oh;
  logic [N-1:0]     upto;
  logic [N-1:0]     svc;
  logic [N-1:0]     set_oh;
  logic             blocked;
  logic             grant;
  logic [VEC_W-1:0] vec_next;

  assign req_en = src_req_i & {N{mie_i}};

  irqv_first #(.N(N)) u_win (
    .vec_i   (req_en),
    .first_o (win_oh)
  );

  // sources at or above the winner's priority
  assign upto    = win_oh | (win_oh - {{(N-1){1'b0}}, 1'b1});
  assign blocked = |(svc & upto);
  assign grant   = (|win_oh) && !blocked;
  assign set_oh  = (ack_i && grant) ? win_oh : '0;

  irqv_service #(.N(N)) u_svc (
    .clk      (clk),
    .rst      (rst),
    .set_oh_i (set_oh),
    .clr_i    (reti_i),
    .svc_o    (svc)
  );

  irqv_encode #(
    .NUM_CH     (NUM_CH),
    .SRC_PER_CH (SRC_PER_CH),
    .VEC_W      (VEC_W),
    .LO_LSB     (LO_LSB),
    .HI_LSB     (HI_LSB)
  ) u_enc (
    .win_oh_i (win_oh),
    .spec_i   (spec_rx_i),
    .base_i   (base_vec_i),
    .vis_i    (vis_i),
    .hi_i     (hi_sel_i),
    .vec_o    (vec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= grant;
      vec_o <= vec_next;
    end
  end

  // R2: master enable low keeps the line low
  p_mie_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !mie_i |=> !irq_o);

  // R6: without status insert the base vector passes unchanged
  p_plain_vec_r6: assert property (@(posedge clk) disable iff (rst)
    !vis_i |=> vec_o == $past(base_vec_i));

  // R7: high insert leaves the low field bits alone
  p_hi_keeps_low_r7: assert property (@(posedge clk) disable iff (rst)
    (vis_i && hi_sel_i) |=> vec_o[HI_LSB-1:0] == $past(base_vec_i[HI_LSB-1:0]));

  // R9: top source in service blocks every request
  p_top_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    svc[0] |=> !irq_o);

  // R9: top source pending and free always raises the line
  p_top_raises_r9: assert property (@(posedge clk) disable iff (rst)
    (mie_i && src_req_i[0] && !svc[0]) |=> irq_o);
endmodule

// File: tb/irq_vector_mod_tb.sv
module irq_vector_mod_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] src_req;
  logic [1:0] spec_rx;
  logic [7:0] base_vec;
  logic       mie, vis, hi_sel, ack, reti;
  logic       irq;
  logic [7:0] vec;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_vector_mod u_dut (
    .clk        (clk),
    .rst        (rst),
    .src_req_i  (src_req),
    .spec_rx_i  (spec_rx),
    .base_vec_i (base_vec),
    .mie_i      (mie),
    .vis_i      (vis),
    .hi_sel_i   (hi_sel),
    .ack_i      (ack),
    .reti_i     (reti),
    .irq_o      (irq),
    .vec_o      (vec)
  );

  // {req, spec, base, mie, vis, hi, exp_irq, exp_vec}
  localparam logic [27:0] TBL [15] = '{
    {6'b000001, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0C},
    {6'b000010, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h08},
    {6'b000100, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0A},
    {6'b001000, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h04},
    {6'b010000, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00},
    {6'b100000, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02},
    {6'b111111, 2'b00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h60},
    {6'b110110, 2'b00, 8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC1},
    {6'b000001, 2'b01, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF},
    {6'b001000, 2'b10, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h06},
    {6'b000000, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h06},
    {6'b000000, 2'b00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h30},
    {6'b000001, 2'b00, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5},
    {6'b000001, 2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h06},
    {6'b001000, 2'b01, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h04}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic chk_vec(input logic [7:0] exp, input string tag);
    checks++;
    if (vec !== exp) begin
      fails++;
      $display("FAIL %s vec actual=%02h expected=%02h", tag, vec, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ack = 1'b0; reti = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  initial begin
    src_req = '0; spec_rx = '0; base_vec = '0;
    mie = 1'b0; vis = 1'b0; hi_sel = 1'b0;
    #1;
    do_reset();
    // R12: reset state
    chk_irq(1'b0, "R12 reset");
    chk_vec(8'h00, "R12 reset");

    // R1 R3 R4 R5 R6 R7 table walk (nothing in service)
    for (int r = 0; r < 15; r++) begin
      src_req  = TBL[r][27:22];
      spec_rx  = TBL[r][21:20];
      base_vec = TBL[r][19:12];
      mie      = TBL[r][11];
      vis      = TBL[r][10];
      hi_sel   = TBL[r][9];
      tick();
      chk_irq(TBL[r][8], $sformatf("R1 R3 R4 R5 R6 R7 row %0d", r));
      chk_vec(TBL[r][7:0], $sformatf("R1 R3 R4 R5 R6 R7 row %0d", r));
    end

    // R12: one-edge latency
    do_reset();
    mie = 1'b1; vis = 1'b1; hi_sel = 1'b0; base_vec = 8'h00; spec_rx = '0;
    src_req = 6'b000010;
    #1;
    chk_irq(1'b0, "R12 before edge");
    tick();
    chk_irq(1'b1, "R12 after edge");
    chk_vec(8'h08, "R12 after edge");

    // R8: acknowledge puts channel A transmit in service
    pulse_ack();
    tick();
    chk_irq(1'b0, "R8 served source drops");
    // R9: lower priority stays blocked
    src_req = 6'b001010;
    tick();
    chk_irq(1'b0, "R9 lower blocked");
    // R9: higher priority nests
    src_req = 6'b001011;
    tick();
    chk_irq(1'b1, "R9 higher nests");
    chk_vec(8'h0C, "R9 higher nests");
    pulse_ack();
    tick();
    chk_irq(1'b0, "R8 both in service");
    // R10: return retires receive (top), transmit stays
    pulse_reti();
    tick();
    chk_irq(1'b1, "R10 top retired first");
    pulse_reti();
    src_req = 6'b001010;
    tick();
    chk_irq(1'b1, "R10 set empty");
    chk_vec(8'h08, "R10 set empty");

    // R11: acknowledge and return on the same edge
    do_reset();
    mie = 1'b1; vis = 1'b1; hi_sel = 1'b0; base_vec = 8'h00;
    src_req = 6'b000010;
    tick();
    pulse_ack();
    src_req = 6'b000011;
    tick();
    chk_irq(1'b1, "R11 setup");
    ack = 1'b1; reti = 1'b1;
    tick();
    ack = 1'b0; reti = 1'b0;
    src_req = 6'b000001;
    tick();
    chk_irq(1'b0, "R11 receive in service");
    pulse_reti();
    src_req = 6'b000010;
    tick();
    chk_irq(1'b1, "R11 transmit retired");

    // R2: acknowledge ignored with master enable low
    do_reset();
    mie = 1'b0; src_req = 6'b000100;
    tick();
    chk_irq(1'b0, "R2 gated");
    pulse_ack();
    mie = 1'b1;
    tick();
    chk_irq(1'b1, "R2 ack had no effect");
    chk_vec(8'h0A, "R2 ack had no effect");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule